// File: doc/BRIEF.md
# Quarter-bit input aligner

This block lines up a set of serial time-division-multiplexed input streams with a common frame. It runs on a clock at four times the bit rate, so each bit period holds four quarter cycles. A frame pulse fixes quarter 0 of bit 0. For each stream, a 5-bit delay setting selects which quarter of the bit period the input is captured in, and how many whole bit periods the captured value is held back before it is presented. All streams present one aligned bit per bit period, with a shared valid strobe.

Each stream's setting is written through a simple write port. The stream index is the write address, and the field sits in the low five data bits. A global mode input selects how the field is read. In linear mode, the field counts quarter-bit steps of delay beyond a nominal capture point at 3/4 of the bit. In split mode, the upper three field bits give a whole-bit delay and the lower two bits pick the capture quarter. New settings and a new mode take effect only at the next frame pulse. A frame therefore never runs with a half-applied delay.

Top module: `qbit_align`

## Requirements
- R1: While reset is low, `bit_out` is all zero and `bit_vld` is low. After reset every field is 0 and the mode is linear until a frame pulse loads new values, so the first frame captures each stream at quarter 2 (the 3/4 point) with no whole-bit delay.
- R2: The cycle in which `frame_p` is high is quarter 0 of a bit period. Quarters then count 0,1,2,3 and repeat. `bit_vld` is high for exactly the one cycle that follows each quarter-3 cycle and is low otherwise.
- R3: Linear mode (`split_mode` latched low). Let F be the field and t = F + 2. The bit presented after bit period n is the input value seen in quarter (t mod 4) of bit period n − floor(t/4). This spans 0 to 7.75 bits of delay beyond the 3/4 point, in quarter-bit steps.
- R4: Split mode (`split_mode` latched high). The whole-bit delay is F[4:2] (0 to 7). Phase code F[1:0] selects the capture quarter: 00 gives quarter 2 (3/4 point), 01 gives quarter 3 (4/4), 10 gives quarter 0 (1/4) and 11 gives quarter 1 (2/4).
- R5: In linear mode a field of 19 delays the stream by 4.75 bits beyond the 3/4 point. The bit presented after period n is the one captured in quarter 1 of period n − 5.
- R6: A write with `cfg_we` high loads `cfg_wdata[4:0]` as the field of stream `cfg_addr`. Data bits above bit 4 are reserved and have no effect on any output.
- R7: Field writes and changes of `split_mode` made during a frame change nothing until the next frame pulse. From the cycle of that pulse, all of them apply together. A captured bit keeps the capture quarter of the frame it was taken in.
- R8: `bit_out` changes only in cycles where `bit_vld` is high and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk4x | input | 1 | Clock at four times the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_p | input | 1 | Frame pulse; its cycle is quarter 0 of bit 0 |
| split_mode | input | 1 | Field interpretation: 0 linear, 1 split whole/quarter |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | $clog2(N_STREAMS) | Stream index for the write |
| cfg_wdata | input | REG_W | Write data; field in bits 4:0, upper bits reserved |
| ser_in | input | N_STREAMS | Serial input, one bit per stream |
| bit_out | output | N_STREAMS | Aligned captured bit per stream |
| bit_vld | output | 1 | One-cycle strobe marking a new `bit_out` |

## Verification
The hardest case to reach from the ports is a captured bit that crosses a frame boundary where the settings change. In that case the output still shows the capture quarter of the old frame while the whole-bit delay of the new frame applies. The stimulus gives every stream a fixed skew of its own, in quarters. It rewrites all sixteen fields and flips the mode in the middle of a frame, then keeps running across the boundary. The first bits of each new frame therefore draw on history captured under the previous settings. Each field value from 0 to 31 is visited in both modes, and two rounds of writes carry non-zero reserved bits.

// File: rtl/qbit_align_pkg.sv
package qbit_align_pkg;

    localparam int FIELD_W   = 5;
    // quarter index of the nominal capture point (3/4 of the bit)
    localparam int NOMINAL_Q = 2;
    localparam int MAX_WHOLE = ((1 << FIELD_W) - 1 + NOMINAL_Q) >> 2;
    localparam int HIST_D    = MAX_WHOLE + 1;
    localparam int WHOLE_W   = $clog2(HIST_D);

    typedef logic [FIELD_W-1:0] field_t;

    typedef struct packed {
        logic [WHOLE_W-1:0] whole;
        logic [1:0]         quarter;
    } tap_t;

    // Turn a field into a whole-bit tap and a capture quarter.
    function automatic tap_t decode_tap(field_t f, logic split);
        tap_t               t;
        logic [FIELD_W:0]   lin;
        lin = {1'b0, f} + (FIELD_W+1)'(NOMINAL_Q);
        if (split) begin
            t.whole   = WHOLE_W'(f[FIELD_W-1:2]);
            t.quarter = f[1:0] + 2'd2;
        end else begin
            t.whole   = WHOLE_W'(lin[FIELD_W:2]);
            t.quarter = lin[1:0];
        end
        return t;
    endfunction

endpackage

// File: rtl/qbit_align_phase.sv
module qbit_align_phase (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fp,
    output logic [1:0] phase,
    output logic       bit_end,
    output logic       bit_vld
);
    typedef struct packed {
        logic [1:0] ph;
        logic       vld;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ph  = fp ? 2'd0 : st_q.ph + 2'd1;
        st_d.vld = (st_d.ph == 2'd3);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= 2'd3;
            st_q.vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase   = st_d.ph;
    assign bit_end = (st_d.ph == 2'd3);
    assign bit_vld = st_q.vld;

endmodule

// File: rtl/qbit_align_cfg.sv
module qbit_align_cfg #(
    parameter int N_STREAMS = 16,
    parameter int REG_W     = 16,
    parameter int ADDR_W    = 4
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        fp,
    input  logic                                        mode_in,
    input  logic                                        wr_en,
    input  logic [ADDR_W-1:0]                           wr_addr,
    input  logic [REG_W-1:0]                            wr_data,
    output qbit_align_pkg::field_t [N_STREAMS-1:0]      eff_field,
    output logic                                        eff_split
);
    import qbit_align_pkg::*;

    typedef struct packed {
        field_t [N_STREAMS-1:0] stage;
        field_t [N_STREAMS-1:0] act;
        logic                   act_split;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    // reserved data bits are accepted and dropped
    logic resv_unused;
    assign resv_unused = ^wr_data[REG_W-1:FIELD_W];

    always_comb begin
        st_d = st_q;
        if (fp) begin
            st_d.act       = st_q.stage;
            st_d.act_split = mode_in;
        end
        for (int i = 0; i < N_STREAMS; i++) begin
            if (wr_en && (wr_addr == ADDR_W'(i))) begin
                st_d.stage[i] = wr_data[FIELD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // the frame-pulse cycle already runs on the new settings
    assign eff_field = fp ? st_q.stage : st_q.act;
    assign eff_split = fp ? mode_in    : st_q.act_split;

endmodule

// File: rtl/qbit_align_lane.sv
module qbit_align_lane (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    din,
    input  logic [1:0]              phase,
    input  logic                    bit_end,
    input  qbit_align_pkg::field_t  field,
    input  logic                    split,
    output logic                    dout
);
    import qbit_align_pkg::*;

    typedef struct packed {
        logic              samp;
        logic [HIST_D-1:0] hist;
        logic              dout;
    } lane_st_t;

    lane_st_t st_d, st_q;
    tap_t     tap;
    logic     cur_smp;

    always_comb begin
        st_d    = st_q;
        tap     = decode_tap(field, split);
        cur_smp = (phase == tap.quarter) ? din : st_q.samp;
        st_d.samp = cur_smp;
        if (bit_end) begin
            st_d.hist = {st_q.hist[HIST_D-2:0], cur_smp};
            st_d.dout = st_d.hist[tap.whole];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.dout;

endmodule

// File: rtl/qbit_align.sv
module qbit_align #(
    parameter int N_STREAMS = 16,
    parameter int REG_W     = 16
) (
    input  logic                          clk4x,
    input  logic                          rst_n,
    input  logic                          frame_p,
    input  logic                          split_mode,
    input  logic                          cfg_we,
    input  logic [$clog2(N_STREAMS)-1:0]  cfg_addr,
    input  logic [REG_W-1:0]              cfg_wdata,
    input  logic [N_STREAMS-1:0]          ser_in,
    output logic [N_STREAMS-1:0]          bit_out,
    output logic                          bit_vld
);
    import qbit_align_pkg::*;

    localparam int ADDR_W = $clog2(N_STREAMS);

    logic [1:0]              phase_w;
    logic                    bit_end_w;
    field_t [N_STREAMS-1:0]  eff_field_w;
    logic                    eff_split_w;

    qbit_align_phase phase_i (
        .clk     (clk4x),
        .rst_n   (rst_n),
        .fp      (frame_p),
        .phase   (phase_w),
        .bit_end (bit_end_w),
        .bit_vld (bit_vld)
    );

    qbit_align_cfg #(
        .N_STREAMS (N_STREAMS),
        .REG_W     (REG_W),
        .ADDR_W    (ADDR_W)
    ) cfg_i (
        .clk       (clk4x),
        .rst_n     (rst_n),
        .fp        (frame_p),
        .mode_in   (split_mode),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .eff_field (eff_field_w),
        .eff_split (eff_split_w)
    );

    for (genvar gi = 0; gi < N_STREAMS; gi++) begin : g_lane
        qbit_align_lane lane_i (
            .clk     (clk4x),
            .rst_n   (rst_n),
            .din     (ser_in[gi]),
            .phase   (phase_w),
            .bit_end (bit_end_w),
            .field   (eff_field_w[gi]),
            .split   (eff_split_w),
            .dout    (bit_out[gi])
        );
    end

endmodule

// File: rtl/qbit_align_chk.sv
module qbit_align_chk #(
    parameter int N_STREAMS = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   fp,
    input  logic                                   vld,
    input  logic [1:0]                             phase,
    input  logic [N_STREAMS-1:0]                   dout,
    input  qbit_align_pkg::field_t [N_STREAMS-1:0] eff_field,
    input  logic                                   eff_split
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (dout == '0 && !vld));

    // R2
    fp_quarter0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fp |-> (phase == 2'd0));

    // R2
    vld_after_q3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3) |=> vld);

    // R2
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |-> $stable(dout));

    // R7
    cfg_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fp |=> (fp || ($stable(eff_field) && $stable(eff_split))));

endmodule

bind qbit_align qbit_align_chk #(.N_STREAMS(N_STREAMS)) chk_i (
    .clk       (clk4x),
    .rst_n     (rst_n),
    .fp        (frame_p),
    .vld       (bit_vld),
    .phase     (phase_w),
    .dout      (bit_out),
    .eff_field (eff_field_w),
    .eff_split (eff_split_w)
);

// File: tb/qbit_align_tb_top.sv
`timescale 1ns/1ps
module qbit_align_tb_top;

    localparam int N          = 16;
    localparam int FRAME_BITS = 32;
    localparam int FRAME_Q    = FRAME_BITS * 4;
    localparam int OFS        = 64;
    localparam int WD_CYCLES  = 100000;

    logic          clk = 1'b0;
    logic          rst_n, frame_p, split_mode, cfg_we;
    logic [3:0]    cfg_addr;
    logic [15:0]   cfg_wdata;
    logic [N-1:0]  ser_in, bit_out;
    logic          bit_vld;

    always #2.5 clk = ~clk;

    qbit_align #(.N_STREAMS(N), .REG_W(16)) dut_i (
        .clk4x(clk), .rst_n(rst_n), .frame_p(frame_p), .split_mode(split_mode),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .ser_in(ser_in), .bit_out(bit_out), .bit_vld(bit_vld)
    );

    typedef struct packed {
        logic [N-1:0]      bits;
        logic [N-1:0][3:0] req;
    } exp_t;

    exp_t        exp_q[$];
    int          checks = 0, errors = 0;
    int          g = 0, cur_g = 0;
    bit          running = 0, done = 0, junk_round = 0;
    logic [4:0]  stage_m[N], act_m[N], prev_m[N];
    bit          act_sp = 0, prev_sp = 0;
    logic [N-1:0] last_out;

    function automatic bit pat_bit(int st, int k);
        int unsigned x;
        x = k * 32'd1103515245 + st * 32'd12345 + 32'd777;
        x = x ^ (x >> 13);
        return x[7] ^ x[19];
    endfunction

    function automatic int skew_of(int st);
        return (st * 7) % 13;
    endfunction

    // R3 / R4: whole-bit delay
    function automatic int whole_of(logic [4:0] f, bit sp);
        if (sp) return int'(f) / 4;
        return (int'(f) + 2) / 4;
    endfunction

    // R3 / R4: capture quarter
    function automatic int quarter_of(logic [4:0] f, bit sp);
        if (!sp) return (int'(f) + 2) % 4;
        case (f[1:0])
            2'b00:   return 2;
            2'b01:   return 3;
            2'b10:   return 0;
            default: return 1;
        endcase
    endfunction

    task automatic push_expect(int b);
        exp_t e;
        for (int st = 0; st < N; st++) begin
            int d, src, q;
            bit same;
            logic [4:0] fs;
            bit sps;
            d    = whole_of(act_m[st], act_sp);
            src  = b - d;
            same = (src / FRAME_BITS) == (b / FRAME_BITS);
            fs   = same ? act_m[st] : prev_m[st];
            sps  = same ? act_sp : prev_sp;
            q    = quarter_of(fs, sps);
            e.bits[st] = pat_bit(st, (4 * src + q - skew_of(st) + OFS) >> 2);
            if (b / FRAME_BITS == 0)                          e.req[st] = 4'd1;
            else if (junk_round)                              e.req[st] = 4'd6;
            else if (!same && (fs != act_m[st] || sps != act_sp)) e.req[st] = 4'd7;
            else if (!act_sp && act_m[st] == 5'd19)           e.req[st] = 4'd5;
            else if (act_sp)                                  e.req[st] = 4'd4;
            else                                              e.req[st] = 4'd3;
        end
        exp_q.push_back(e);
    endtask

    // driver: one cycle of stimulus and model update
    task automatic step(input bit we, input int addr, input logic [15:0] data);
        @(negedge clk);
        frame_p = (g % FRAME_Q == 0);
        if (frame_p) begin
            for (int st = 0; st < N; st++) begin
                prev_m[st] = act_m[st];
                act_m[st]  = stage_m[st];
            end
            prev_sp = act_sp;
            act_sp  = split_mode;
        end
        for (int st = 0; st < N; st++)
            ser_in[st] = pat_bit(st, (g - skew_of(st) + OFS) >> 2);
        cfg_we    = we;
        cfg_addr  = addr[3:0];
        cfg_wdata = data;
        if (we) stage_m[addr] = data[4:0];
        if (g % 4 == 3) push_expect(g / 4);
        cur_g   = g;
        g       = g + 1;
        running = 1;
    endtask

    // R6 / R7: writes and mode change mid-frame, then run across boundaries
    task automatic cfg_round(input int base, input bit sp, input bit junk);
        split_mode = sp;
        junk_round = junk;
        for (int i = 0; i < N; i++) begin
            logic [4:0]  f;
            logic [10:0] hi;
            f  = junk ? 5'((i * 5 + base) & 31) : 5'((i + base) & 31);
            hi = junk ? 11'((i * 397 + 1231) & 11'h7FF) | 11'h401 : 11'h000;
            step(1'b1, i, {hi, f});
        end
        while (g % FRAME_Q != 0) step(1'b0, 0, 16'h0000);
        for (int k = 0; k < 2 * FRAME_Q; k++) step(1'b0, 0, 16'h0000);
    endtask

    // monitor: pops expectations when the design strobes a result
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (running && !done) begin
                bit exp_v;
                exp_v = (cur_g % 4 == 0) && (cur_g > 0);
                checks++;
                if (bit_vld !== exp_v) begin
                    errors++;
                    $display("FAIL R2 cycle %0d: bit_vld actual %b expected %b", cur_g, bit_vld, exp_v);
                end
                if (bit_vld) begin
                    if (exp_q.size() == 0) begin
                        checks++; errors++;
                        $display("FAIL R2 cycle %0d: strobe with no expectation, actual 1 expected 0", cur_g);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        for (int st = 0; st < N; st++) begin
                            checks++;
                            if (bit_out[st] !== e.bits[st]) begin
                                errors++;
                                $display("FAIL R%0d stream %0d cycle %0d: actual %b expected %b",
                                         e.req[st], st, cur_g, bit_out[st], e.bits[st]);
                            end
                        end
                    end
                end else begin
                    // R8
                    checks++;
                    if (bit_out !== last_out) begin
                        errors++;
                        $display("FAIL R8 cycle %0d: actual %h expected %h", cur_g, bit_out, last_out);
                    end
                end
                last_out = bit_out;
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R2 watchdog: actual %0d cycles without completion, expected fewer", WD_CYCLES);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; frame_p = 1'b0; split_mode = 1'b0; cfg_we = 1'b0;
        cfg_addr = '0; cfg_wdata = '0; ser_in = '0; last_out = '0;
        for (int st = 0; st < N; st++) begin
            stage_m[st] = '0; act_m[st] = '0; prev_m[st] = '0;
        end
        repeat (4) @(negedge clk);
        // R1
        checks++;
        if (bit_out !== '0 || bit_vld !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual out %h vld %b expected 0 0", bit_out, bit_vld);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // first frame on reset settings (R1)
        for (int k = 0; k < FRAME_Q; k++) step(1'b0, 0, 16'h0000);
        cfg_round(0,  1'b0, 1'b0);   // R3
        cfg_round(16, 1'b0, 1'b0);   // R3, R5 (stream 3 gets 19)
        cfg_round(0,  1'b1, 1'b0);   // R4, R7 mode flip
        cfg_round(16, 1'b1, 1'b0);   // R4
        cfg_round(7,  1'b0, 1'b1);   // R6
        cfg_round(3,  1'b1, 1'b1);   // R6
        repeat (4) step(1'b0, 0, 16'h0000);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule